// File: doc/BRIEF.md
# SM4 Byte-Lane Round Step Unit

This unit performs one byte-wide step of the SM4 round function or of the SM4 key expansion. Each accepted operation takes an accumulator word, a round-input word, a byte select and a mode bit. It picks one byte of the round-input word and passes it through the SM4 substitution box. It spreads the substituted byte over a 32-bit word with the linear layer the mode selects, rotates that word into the selected byte lane and XORs it into the accumulator.

A caller builds a whole round by issuing four steps with byte selects 0, 1, 2 and 3. The first step uses the first state word as the accumulator and every step uses the XOR of the other three state words and the round key as the round input. Each later step takes the previous result as its accumulator. The 32-bit result is sign-extended to the configured register width and registered. Latency is one clock for every operand value.

The output stage is a two-state machine. ST_EMPTY means no fresh result is presented, and ST_LOADED means the result register holds the answer to the operation accepted on the previous edge. Both states go to ST_LOADED on an edge where `in_valid` is high and to ST_EMPTY on an edge where it is low. Reset enters ST_EMPTY.

Top module: `sm4_slice_step`

## Requirements
- R1: While reset is held and right after it, `out_valid` is 0 and `result_out` is all zeros.
- R2: `out_valid` is 1 exactly in the cycle after an edge where `in_valid` was 1, and 0 after an edge where `in_valid` was 0. Back-to-back operations are accepted on every clock.
- R3: Only `sel_in[1:0]` matters. The upper bits of `sel_in` have no effect on the result.
- R4: The byte selected by `sel_in[1:0]` (0 picks bits 7:0, 1 picks 15:8, 2 picks 23:16, 3 picks 31:24) goes through the SM4 S-box. Examples: 0x00 gives 0xD6, 0x01 gives 0x90, 0x80 gives 0xEA, 0xFF gives 0x48.
- R5: With `mode_in` = 0 (cipher), the zero-extended S-box output b is spread as b ^ rotl(b,2) ^ rotl(b,10) ^ rotl(b,18) ^ rotl(b,24).
- R6: With `mode_in` = 1 (key expansion), the spread is b ^ rotl(b,13) ^ rotl(b,23).
- R7: The spread word is rotated left by 8 times `sel_in[1:0]` and XORed with `acc_in`. This gives the low 32 bits of the result.
- R8: Four chained steps with selects 0 to 3 in cipher mode yield x0 ^ L(S(a3),S(a2),S(a1),S(a0)). Here a is the round input and L is the full-word cipher linear layer.
- R9: On an edge with `in_valid` low, `result_out` keeps its value.
- R10: Bits XLEN-1 to 32 of `result_out` are copies of bit 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation strobe |
| acc_in | input | 32 | Accumulator word |
| src_in | input | 32 | Round-input word that supplies the byte |
| sel_in | input | SEL_W | Byte select, only low 2 bits used |
| mode_in | input | 1 | 0 cipher linear layer, 1 key-expansion linear layer |
| out_valid | output | 1 | Result presented this cycle |
| result_out | output | XLEN | Sign-extended step result |

## Verification
Every result and its valid flag are due on the first rising edge after the strobe edge, because exactly one register sits between inputs and outputs. Idle cycles must show the previous result unchanged with the flag low. The bench drives inputs on falling edges and updates its reference at the same rising edge as the design. It compares both outputs on every falling edge, half a period after they change. Chained round checks read each result at the falling edge that follows its strobe and feed it back as the next accumulator.

// File: rtl/sm4s_pkg.sv
package sm4s_pkg;

    localparam int WORD_W = 32;
    localparam int BYTE_W = 8;
    localparam int LANES  = WORD_W / BYTE_W;
    localparam int LSEL_W = $clog2(LANES);

    // rotation amounts of the two linear layers
    localparam int unsigned CIPH_R0 = 2;
    localparam int unsigned CIPH_R1 = 10;
    localparam int unsigned CIPH_R2 = 18;
    localparam int unsigned CIPH_R3 = 24;
    localparam int unsigned KEY_R0  = 13;
    localparam int unsigned KEY_R1  = 23;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic {
        DIFF_CIPHER = 1'b0,
        DIFF_KEY    = 1'b1
    } diff_mode_e;

    typedef enum logic {
        ST_EMPTY  = 1'b0,
        ST_LOADED = 1'b1
    } stage_state_e;

    function automatic word_t rotl(word_t w, int unsigned n);
        int unsigned k;
        k = n % WORD_W;
        if (k == 0) return w;
        return (w << k) | (w >> (WORD_W - k));
    endfunction

    function automatic word_t rotr(word_t w, int unsigned n);
        int unsigned k;
        k = n % WORD_W;
        if (k == 0) return w;
        return (w >> k) | (w << (WORD_W - k));
    endfunction

endpackage

// File: rtl/sm4s_sbox.sv
module sm4s_sbox
    import sm4s_pkg::*;
(
    input  byte_t din,
    output byte_t dout
);

    logic [127:0] row;
    logic [3:0]   col;

    // sixteen rows of sixteen bytes, column 0 in the top byte
    always_comb begin
        unique case (din[7:4])
            4'h0: row = 128'hD690E9FECCE13DB716B614C228FB2C05;
            4'h1: row = 128'h2B679A762ABE04C3AA44132649860699;
            4'h2: row = 128'h9C4250F491EF987A33540B43EDCFAC62;
            4'h3: row = 128'hE4B31CA9C908E89580DF94FA758F3FA6;
            4'h4: row = 128'h4707A7FCF37317BA83593C19E6854FA8;
            4'h5: row = 128'h686B81B27164DA8BF8EB0F4B70569D35;
            4'h6: row = 128'h1E240E5E6358D1A225227C3B01217887;
            4'h7: row = 128'hD40046579FD327524C3602E7A0C4C89E;
            4'h8: row = 128'hEABF8AD240C738B5A3F7F2CEF96115A1;
            4'h9: row = 128'hE0AE5DA49B341A55AD933230F58CB1E3;
            4'hA: row = 128'h1DF6E22E8266CA60C02923AB0D534E6F;
            4'hB: row = 128'hD5DB3745DEFD8E2F03FF6A726D6C5B51;
            4'hC: row = 128'h8D1BAF92BBDDBC7F11D95C411F105AD8;
            4'hD: row = 128'h0AC13188A5CD7BBD2D74D012B8E5B4B0;
            4'hE: row = 128'h8969974A0C96777E65B9F109C56EC684;
            4'hF: row = 128'h18F07DEC3ADC4D2079EE5F3ED7CB3948;
        endcase
    end

    assign col  = din[3:0];
    assign dout = row[{~col, 3'b000} +: 8];

endmodule

// File: rtl/sm4s_diffuse.sv
module sm4s_diffuse
    import sm4s_pkg::*;
(
    input  diff_mode_e mode,
    input  byte_t      sub_b,
    output word_t      spread_w
);

    word_t zext;

    always_comb begin
        zext = {{(WORD_W-BYTE_W){1'b0}}, sub_b};
        unique case (mode)
            DIFF_CIPHER: spread_w = zext ^ rotl(zext, CIPH_R0) ^ rotl(zext, CIPH_R1)
                                         ^ rotl(zext, CIPH_R2) ^ rotl(zext, CIPH_R3);
            DIFF_KEY:    spread_w = zext ^ rotl(zext, KEY_R0) ^ rotl(zext, KEY_R1);
        endcase
    end

endmodule

// File: rtl/sm4s_lane.sv
module sm4s_lane
    import sm4s_pkg::*;
(
    input  word_t             src_w,
    input  logic [LSEL_W-1:0] sel,
    input  word_t             diff_w,
    output byte_t             lane_byte,
    output word_t             placed_w
);

    byte_t lanes [LANES];
    word_t rots  [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lanes[g] = src_w[g*BYTE_W +: BYTE_W];
        assign rots[g]  = rotl(diff_w, g*BYTE_W);
    end

    assign lane_byte = lanes[sel];
    assign placed_w  = rots[sel];

endmodule

// File: rtl/sm4_slice_step.sv
module sm4_slice_step
    import sm4s_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int SEL_W = 4
)
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] acc_in,
    input  logic [WORD_W-1:0] src_in,
    input  logic [SEL_W-1:0]  sel_in,
    input  logic              mode_in,
    output logic              out_valid,
    output logic [XLEN-1:0]   result_out
);

    logic [LSEL_W-1:0] lane_sel;
    byte_t             lane_byte;
    byte_t             sub_byte;
    word_t             spread_w;
    word_t             placed_w;
    word_t             sum_w;
    logic [XLEN-1:0]   ext_w;
    logic [XLEN-1:0]   res_q;
    stage_state_e      state_q;
    stage_state_e      state_d;

    assign lane_sel = sel_in[LSEL_W-1:0];

    if (SEL_W > LSEL_W) begin : g_sel_hi
        logic [SEL_W-LSEL_W-1:0] sel_unused;
        assign sel_unused = sel_in[SEL_W-1:LSEL_W];
    end

    sm4s_lane u_lane (
        .src_w     (src_in),
        .sel       (lane_sel),
        .diff_w    (spread_w),
        .lane_byte (lane_byte),
        .placed_w  (placed_w)
    );

    sm4s_sbox u_sbox (
        .din  (lane_byte),
        .dout (sub_byte)
    );

    sm4s_diffuse u_diff (
        .mode     (diff_mode_e'(mode_in)),
        .sub_b    (sub_byte),
        .spread_w (spread_w)
    );

    assign sum_w = acc_in ^ placed_w;

    if (XLEN > WORD_W) begin : g_sext
        assign ext_w = {{(XLEN-WORD_W){sum_w[WORD_W-1]}}, sum_w};
    end else begin : g_plain
        assign ext_w = sum_w;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        unique case (state_q)
            ST_EMPTY:  state_d = in_valid ? ST_LOADED : ST_EMPTY;
            ST_LOADED: state_d = in_valid ? ST_LOADED : ST_EMPTY;
        endcase
    end

    // result register, loaded only by an accepted operation
    always_ff @(posedge clk) begin
        if (!rst_n)        res_q <= '0;
        else if (in_valid) res_q <= ext_w;
    end

    // outputs
    always_comb begin
        out_valid  = (state_q == ST_LOADED);
        result_out = res_q;
    end

endmodule

// File: rtl/sm4_slice_step_chk.sv
module sm4_slice_step_chk
    import sm4s_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int SEL_W = 4
)
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [WORD_W-1:0] acc_in,
    input logic [SEL_W-1:0]  sel_in,
    input logic              mode_in,
    input logic              out_valid,
    input logic [XLEN-1:0]   result_out
);

    logic              vld_d;
    logic              mode_d;
    logic [LSEL_W-1:0] sel_d;
    word_t             acc_d;
    word_t             delta;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_d  <= 1'b0;
            mode_d <= 1'b0;
            sel_d  <= '0;
            acc_d  <= '0;
        end else begin
            vld_d  <= in_valid;
            mode_d <= mode_in;
            sel_d  <= sel_in[LSEL_W-1:0];
            acc_d  <= acc_in;
        end
    end

    // contribution brought back to lane 0
    assign delta = rotr(result_out[WORD_W-1:0] ^ acc_d, 32'(sel_d) * BYTE_W);

    function automatic logic key_shape(word_t d);
        return (d[31] == 1'b0) && (d[22:21] == 2'b00) && (d[12:8] == 5'd0)
            && (d[20:13] == d[7:0]) && (d[30:23] == d[7:0]);
    endfunction

    assert_valid_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_valid_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result_out));

    assert_sext_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((&result_out[XLEN-1:WORD_W-1]) || (~|result_out[XLEN-1:WORD_W-1])));

    assert_key_layer_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_d && mode_d) |-> key_shape(delta));

endmodule

bind sm4_slice_step sm4_slice_step_chk #(.XLEN(XLEN), .SEL_W(SEL_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .acc_in     (acc_in),
    .sel_in     (sel_in),
    .mode_in    (mode_in),
    .out_valid  (out_valid),
    .result_out (result_out)
);

// File: tb/sim_sm4_slice_step.sv
module sim_sm4_slice_step;

    localparam int XLEN  = 64;
    localparam int SEL_W = 4;

    logic              clk;
    logic              rst_n;
    logic              in_valid;
    logic [31:0]       acc_in;
    logic [31:0]       src_in;
    logic [SEL_W-1:0]  sel_in;
    logic              mode_in;
    logic              out_valid;
    logic [XLEN-1:0]   result_out;

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_req = "R1";
    logic  cmp_en = 1'b0;

    logic            exp_v;
    logic [XLEN-1:0] exp_r;

    sm4_slice_step #(.XLEN(XLEN), .SEL_W(SEL_W)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .acc_in     (acc_in),
        .src_in     (src_in),
        .sel_in     (sel_in),
        .mode_in    (mode_in),
        .out_valid  (out_valid),
        .result_out (result_out)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    // published S-box values for the bytes the stimulus uses (R4)
    function automatic int sbox_ref(logic [7:0] b);
        case (b)
            8'h00: return 'hD6;
            8'h01: return 'h90;
            8'h0F: return 'h05;
            8'h10: return 'h2B;
            8'h23: return 'hF4;
            8'h5A: return 'h0F;
            8'h7F: return 'h9E;
            8'h80: return 'hEA;
            8'hA5: return 'h66;
            8'hC8: return 'h11;
            8'hE7: return 'h7E;
            8'hFF: return 'h48;
            default: return -1;
        endcase
    endfunction

    function automatic logic [31:0] rot_ref(logic [31:0] x, int n);
        logic [31:0] y;
        for (int i = 0; i < 32; i++) y[(i + n) % 32] = x[i];
        return y;
    endfunction

    function automatic logic [31:0] layer_ref(logic key_mode, logic [31:0] z);
        if (key_mode) return z ^ rot_ref(z, 13) ^ rot_ref(z, 23);
        return z ^ rot_ref(z, 2) ^ rot_ref(z, 10) ^ rot_ref(z, 18) ^ rot_ref(z, 24);
    endfunction

    function automatic logic [XLEN-1:0] step_ref(logic [31:0] acc, logic [31:0] src,
                                                 logic [SEL_W-1:0] sel, logic key_mode);
        int          lane;
        int          s;
        logic [31:0] r;
        lane = int'(sel[1:0]);
        s    = sbox_ref(src[lane*8 +: 8]);
        if (s < 0) return 'x;
        r = acc ^ rot_ref(layer_ref(key_mode, 32'(s)), 8 * lane);
        return {{(XLEN-32){r[31]}}, r};
    endfunction

    // cycle reference
    always @(posedge clk) begin
        if (!rst_n) begin
            exp_v <= 1'b0;
            exp_r <= '0;
        end else begin
            exp_v <= in_valid;
            if (in_valid) exp_r <= step_ref(acc_in, src_in, sel_in, mode_in);
        end
    end

    // every-cycle comparison, half a period after the outputs move
    always @(negedge clk) begin
        if (cmp_en) begin
            n_cmp++;
            if (out_valid !== exp_v || result_out !== exp_r) begin
                n_bad++;
                $display("FAIL %s: valid=%0b result=%h expected valid=%0b result=%h",
                         cur_req, out_valid, result_out, exp_v, exp_r);
            end
        end
    end

    task automatic check(string req, logic [XLEN-1:0] act, logic [XLEN-1:0] expv);
        n_cmp++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic step(logic [31:0] acc, logic [31:0] src, logic [SEL_W-1:0] sel, logic md);
        @(negedge clk);
        in_valid = 1'b1;
        acc_in   = acc;
        src_in   = src;
        sel_in   = sel;
        mode_in  = md;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        summary();
    end

    initial begin
        logic [31:0]     x0;
        logic [31:0]     a;
        logic [31:0]     acc;
        logic [31:0]     big_b;
        logic [XLEN-1:0] r_lo;
        logic [XLEN-1:0] held;

        rst_n = 1'b0; in_valid = 1'b0; acc_in = '0; src_in = '0; sel_in = '0; mode_in = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", {{(XLEN-1){1'b0}}, out_valid}, '0);
        check("R1", result_out, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", result_out, '0);
        cmp_en = 1'b1;

        // R4: key mode, lane 0, zero accumulator: low byte is S(b)
        cur_req = "R4";
        step(32'h0, 32'h0000_0000, 4'd0, 1'b1);
        check("R4", {56'd0, result_out[7:0]}, 64'hD6);
        step(32'h0, 32'h0000_0001, 4'd0, 1'b1);
        check("R4", {56'd0, result_out[7:0]}, 64'h90);
        step(32'h0, 32'h0000_0080, 4'd0, 1'b1);
        check("R4", {56'd0, result_out[7:0]}, 64'hEA);
        step(32'h0, 32'hFF00_0000, 4'd3, 1'b1);
        check("R4", {56'd0, result_out[31:24]}, 64'h48);

        // R5: cipher layer on all lanes
        cur_req = "R5";
        for (int k = 0; k < 4; k++) step(32'h1357_9BDF, 32'hA5C8_E710, SEL_W'(k), 1'b0);
        step(32'h0, 32'h0000_000F, 4'd0, 1'b0);
        check("R5", result_out, step_ref(32'h0, 32'h0000_000F, 4'd0, 1'b0));

        // R6: key-expansion layer on all lanes
        cur_req = "R6";
        for (int k = 0; k < 4; k++) step(32'hFFFF_0000, 32'h7F5A_23C8, SEL_W'(k), 1'b1);

        // R7: lane rotation and accumulator XOR
        cur_req = "R7";
        step(32'hA5A5_A5A5, 32'h0023_0000, 4'd2, 1'b0);
        check("R7", {32'd0, result_out[31:0] ^ 32'hA5A5_A5A5},
              {32'd0, rot_ref(layer_ref(1'b0, 32'hF4), 16)});

        // R3: upper select bits ignored
        cur_req = "R3";
        step(32'h0F0F_0F0F, 32'h1080_E7A5, 4'b0010, 1'b0);
        r_lo = result_out;
        step(32'h0F0F_0F0F, 32'h1080_E7A5, 4'b1110, 1'b0);
        check("R3", result_out, r_lo);

        // R2: back-to-back acceptance and flag timing
        cur_req = "R2";
        @(negedge clk);
        in_valid = 1'b1; acc_in = 32'h1; src_in = 32'hC8FF_0100; sel_in = 4'd1; mode_in = 1'b0;
        @(negedge clk);
        check("R2", {63'd0, out_valid}, 64'd1);
        sel_in = 4'd3; mode_in = 1'b1;
        @(negedge clk);
        check("R2", {63'd0, out_valid}, 64'd1);
        check("R2", result_out, step_ref(32'h1, 32'hC8FF_0100, 4'd3, 1'b1));
        in_valid = 1'b0;
        @(negedge clk);
        check("R2", {63'd0, out_valid}, 64'd0);

        // R9: idle cycles keep the result
        cur_req = "R9";
        held = result_out;
        acc_in = 32'hDEAD_BEEF; src_in = 32'h0; sel_in = 4'd0;
        repeat (4) @(negedge clk);
        check("R9", result_out, held);

        // R10: both signs of bit 31
        cur_req = "R10";
        step(32'h8000_0000, 32'h0, 4'd0, 1'b1);
        check("R10", {32'd0, result_out[63:32]}, {32'd0, {32{result_out[31]}}});
        check("R10", {63'd0, result_out[31]}, 64'd1);
        step(32'h0, 32'h0, 4'd0, 1'b1);
        check("R10", {32'd0, result_out[63:32]}, 64'd0);

        // R8: four chained steps make a cipher round
        cur_req = "R8";
        x0  = 32'h0123_4567;
        a   = 32'hFF5A_2301;
        acc = x0;
        for (int k = 0; k < 4; k++) begin
            step(acc, a, SEL_W'(k), 1'b0);
            acc = result_out[31:0];
        end
        big_b = 32'h480F_F490;
        check("R8", {32'd0, acc}, {32'd0, x0 ^ layer_ref(1'b0, big_b)});

        @(negedge clk);
        cmp_en = 1'b0;
        summary();
    end

endmodule